// File: doc/BRIEF.md
# Synchronous Burst Memory Core

This block is a synthesizable behavioural model of a small single-port synchronous memory with a built-in two-bit burst sequencer. On every rising clock it decodes a set of active-low controls into one of four operations: deselect, begin a burst at an external address, step to the next address of the burst, or stay on the current burst address. The controls are two chip enables, two address strobes with different priority, a burst advance, a global write, a byte-write enable and per-byte write enables. Reads and writes are both one word per clock, and write data is taken in the same cycle as the command.

Read data leaves through a separate output port with a drive flag, not a bidirectional bus. A mode input selects how many registers the read data passes through. In flow-through mode the word is presented after one clock edge. In registered mode it is presented one edge later. An asynchronous active-low output enable gates the drive flag. The low two address bits of a burst follow either a wrapping linear count or an XOR (interleaved) pattern, chosen by an order input.

Top module: `sburst_mem`

## Requirements
- R1: While `rst` is high and on the first sample after it, `drive` is low and `dout` is zero.
- R2: `strb_cpu_n` low with `ce1_n` low and `ce2_n` low begins a read burst at `addr`; `gwr_n`, `bwr_n` and `ben_n` have no effect in that cycle.
- R3: `ce1_n` high masks `strb_cpu_n`. `ce1_n` high with `strb_ctl_n` low is a deselect. `ce1_n` low with `ce2_n` high and either strobe low is a deselect. A deselect writes nothing and drives nothing.
- R4: `strb_ctl_n` low with `strb_cpu_n` high and both enables low begins a burst at `addr`, as a read or a write according to R8.
- R5: When no burst begins and no deselect occurs (both strobes high, or `ce1_n` high with `strb_ctl_n` high), `adv_n` low moves to the next burst address and `adv_n` high stays on the current one. The cycle is a read or a write according to R8.
- R6: With `ilv_sel` low, the k-th access of a burst (k = 0..3) uses low bits (start + k) mod 4, keeps the upper address bits, and wraps back to the start on the fifth access.
- R7: With `ilv_sel` high, the k-th access uses low bits start XOR k.
- R8: `gwr_n` low writes every byte. Otherwise `bwr_n` low writes byte i (`din[8i+7:8i]`) exactly when `ben_n[i]` is low. With `gwr_n` and `bwr_n` both high, the cycle is a read.
- R9: `bwr_n` low with every `ben_n` bit high is a write that changes no byte.
- R10: With `flow_n` low, a read's word is on `dout` with `drive` high after the command's clock edge. With `flow_n` high, it appears after the following edge.
- R11: The output slot of a write or a deselect has `drive` low and `dout` zero. A read drives all bytes whatever `ben_n` holds.
- R12: `oe_n` acts without a clock. When it is high, `drive` is low and `dout` is zero. A read issued with `oe_n` high still moves the burst sequence on.
- R13: In registered mode, read data already in the output register is still driven in the cycle after a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce1_n | input | 1 | First chip enable, active low; also masks the processor strobe |
| ce2_n | input | 1 | Second chip enable, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low, read-only start |
| strb_ctl_n | input | 1 | Controller address strobe, active low, read or write start |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| ben_n | input | NBYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | External word address |
| din | input | NBYTES*BYTE_W | Write data |
| flow_n | input | 1 | Low: flow-through read timing; high: registered |
| ilv_sel | input | 1 | Low: linear burst order; high: interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | NBYTES*BYTE_W | Read data, zero when not driven |
| drive | output | 1 | High while dout carries valid read data |

## Verification
The timing properties assume that `flow_n` keeps the value it had when the command was issued until that command's output slot. If the mode changes in between, each property is relieved by a term on `flow_n`. The bench changes the mode only before issuing a fresh command, and takes the first registered sample as its own expected case. The read properties also accept `oe_n` high in the output slot. The bench never reads a word it has not first written, so every expected value is defined.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

    // operation decoded for one clock
    typedef enum logic [1:0] {
        OPK_IDLE  = 2'd0,
        OPK_START = 2'd1,
        OPK_STEP  = 2'd2,
        OPK_STAY  = 2'd3
    } opk_t;

    typedef struct packed {
        opk_t kind;
        logic wr;
    } cmd_t;

    // low two bits of the k-th burst access
    function automatic logic [1:0] seq_lo(input logic [1:0] start,
                                          input logic [1:0] k,
                                          input logic       ilv);
        return ilv ? (start ^ k) : (start + k);
    endfunction

endpackage

// File: rtl/sburst_decode.sv
module sburst_decode
    import sburst_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwr_n,
    input  logic [NBYTES-1:0] ben_n,
    output cmd_t              cmd,
    output logic [NBYTES-1:0] wmask
);

    logic              req_wr;
    logic [NBYTES-1:0] mask_raw;

    always_comb begin
        req_wr   = !gwr_n || !bwr_n;
        mask_raw = !gwr_n ? {NBYTES{1'b1}} : (!bwr_n ? ~ben_n : {NBYTES{1'b0}});

        if (!ce1_n && !strb_cpu_n) begin
            // processor strobe wins; write inputs do not matter here
            cmd.kind = ce2_n ? OPK_IDLE : OPK_START;
            cmd.wr   = 1'b0;
        end else if (!strb_ctl_n) begin
            if (!ce1_n && !ce2_n) begin
                cmd.kind = OPK_START;
                cmd.wr   = req_wr;
            end else begin
                cmd.kind = OPK_IDLE;
                cmd.wr   = 1'b0;
            end
        end else begin
            cmd.kind = adv_n ? OPK_STAY : OPK_STEP;
            cmd.wr   = req_wr;
        end

        wmask = (cmd.kind != OPK_IDLE && cmd.wr) ? mask_raw : {NBYTES{1'b0}};
    end

endmodule

// File: rtl/sburst_seq.sv
module sburst_seq
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  opk_t              kind,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        cnt_q
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] start_addr;
    logic [1:0]        cnt_nxt;

    always_comb begin
        start_addr = (kind == OPK_START) ? ext_addr : base_q;
        unique case (kind)
            OPK_START: cnt_nxt = 2'd0;
            OPK_STEP:  cnt_nxt = cnt_q + 2'd1;
            default:   cnt_nxt = cnt_q;
        endcase
        cur_addr = {start_addr[ADDR_W-1:2], seq_lo(start_addr[1:0], cnt_nxt, ilv)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else if (kind != OPK_IDLE) begin
            if (kind == OPK_START) base_q <= ext_addr;
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
    parameter int WORDS  = 64,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int DW     = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic [NBYTES-1:0] wmask,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane [WORDS];

        always_ff @(posedge clk) begin
            if (wmask[b]) lane[waddr] <= wdata[b*BYTE_W +: BYTE_W];
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane[raddr];
    end

endmodule

// File: rtl/sburst_rdpath.sv
module sburst_rdpath #(
    parameter int ADDR_W = 6,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              flow_n,
    input  logic              oe_n,
    input  logic [DW-1:0]     rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     dout,
    output logic              drive
);

    logic          rd_v_q;
    logic          pipe_v_q;
    logic [DW-1:0] pipe_d_q;
    logic          sel_v;
    logic [DW-1:0] sel_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_v_q   <= 1'b0;
            raddr    <= '0;
            pipe_v_q <= 1'b0;
            pipe_d_q <= '0;
        end else begin
            rd_v_q   <= rd_go;
            if (rd_go) raddr <= rd_addr;
            pipe_v_q <= rd_v_q;
            pipe_d_q <= rd_v_q ? rdata : '0;
        end
    end

    always_comb begin
        sel_v = flow_n ? pipe_v_q : rd_v_q;
        sel_d = flow_n ? pipe_d_q : rdata;
        drive = sel_v && !oe_n;
        dout  = drive ? sel_d : '0;
    end

endmodule

// File: rtl/sburst_mem.sv
module sburst_mem
    import sburst_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int DW     = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwr_n,
    input  logic [NBYTES-1:0] ben_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     din,
    input  logic              flow_n,
    input  logic              ilv_sel,
    input  logic              oe_n,
    output logic [DW-1:0]     dout,
    output logic              drive
);

    cmd_t              cmd_w;
    logic [NBYTES-1:0] wmask_w;
    logic [ADDR_W-1:0] cur_addr_w;
    logic [ADDR_W-1:0] raddr_w;
    logic [DW-1:0]     rdata_w;
    logic [1:0]        seq_cnt_w;
    logic [1:0]        op_kind_w;
    logic              op_wr_w;
    logic              rd_go_w;

    assign op_kind_w = cmd_w.kind;
    assign op_wr_w   = cmd_w.wr;
    assign rd_go_w   = (cmd_w.kind != OPK_IDLE) && !cmd_w.wr;

    sburst_decode #(.NBYTES(NBYTES)) u_dec (
        .ce1_n      (ce1_n),
        .ce2_n      (ce2_n),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .gwr_n      (gwr_n),
        .bwr_n      (bwr_n),
        .ben_n      (ben_n),
        .cmd        (cmd_w),
        .wmask      (wmask_w)
    );

    sburst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .kind     (cmd_w.kind),
        .ilv      (ilv_sel),
        .ext_addr (addr),
        .cur_addr (cur_addr_w),
        .cnt_q    (seq_cnt_w)
    );

    sburst_array #(.WORDS(WORDS), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
        .clk   (clk),
        .wmask (wmask_w),
        .waddr (cur_addr_w),
        .wdata (din),
        .raddr (raddr_w),
        .rdata (rdata_w)
    );

    sburst_rdpath #(.ADDR_W(ADDR_W), .DW(DW)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_go   (rd_go_w),
        .rd_addr (cur_addr_w),
        .flow_n  (flow_n),
        .oe_n    (oe_n),
        .rdata   (rdata_w),
        .raddr   (raddr_w),
        .dout    (dout),
        .drive   (drive)
    );

endmodule

// File: rtl/sburst_mem_chk.sv
module sburst_mem_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          ce1_n,
    input logic          ce2_n,
    input logic          strb_cpu_n,
    input logic          strb_ctl_n,
    input logic          flow_n,
    input logic          oe_n,
    input logic [1:0]    op_kind,
    input logic          op_wr,
    input logic [1:0]    burst_cnt,
    input logic [DW-1:0] dout,
    input logic          drive
);

    logic op_rd;
    assign op_rd = (op_kind != 2'd0) && !op_wr;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!drive && dout == '0));

    // R2
    cpu_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce1_n && !ce2_n && !strb_cpu_n) |-> (op_kind == 2'd1 && !op_wr));

    // R3
    ctl_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (ce1_n && !strb_ctl_n) |-> (op_kind == 2'd0));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'd2) |=> (burst_cnt == $past(burst_cnt) + 2'd1));

    // R5
    stay_chk: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 2'd3) |=> $stable(burst_cnt));

    // R10
    flow_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (op_rd && !flow_n) |=> (drive || oe_n || flow_n));

    // R11
    flow_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (op_kind != 2'd0 && op_wr && !flow_n) |=> (!drive || flow_n));

    // R11
    pipe_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (op_kind != 2'd0 && op_wr && flow_n) |=> ##1 (!drive || !flow_n));

    // R13
    pipe_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (op_rd && flow_n) |=> ##1 (drive || oe_n || !flow_n));

endmodule

bind sburst_mem sburst_mem_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce1_n      (ce1_n),
    .ce2_n      (ce2_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .flow_n     (flow_n),
    .oe_n       (oe_n),
    .op_kind    (op_kind_w),
    .op_wr      (op_wr_w),
    .burst_cnt  (seq_cnt_w),
    .dout       (dout),
    .drive      (drive)
);

// File: tb/sburst_mem_test.sv
module sburst_mem_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce1_n = 1'b1, ce2_n = 1'b0, strb_cpu_n = 1'b1, strb_ctl_n = 1'b0;
    logic        adv_n = 1'b1, gwr_n = 1'b1, bwr_n = 1'b1;
    logic [3:0]  ben_n = 4'hF;
    logic [5:0]  addr = '0;
    logic [31:0] din = '0;
    logic        flow_n = 1'b0, ilv_sel = 1'b0, oe_n = 1'b0;
    logic [31:0] dout;
    logic        drive;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sburst_mem uut (
        .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .ben_n(ben_n), .addr(addr), .din(din),
        .flow_n(flow_n), .ilv_sel(ilv_sel), .oe_n(oe_n), .dout(dout), .drive(drive)
    );

    typedef struct packed {
        logic        ce1_n, ce2_n, cpu_n, ctl_n, adv_n, gw_n, bw_n;
        logic [3:0]  ben_n;
        logic [5:0]  addr;
        logic [31:0] din;
        logic        flow_n, ilv, oe_n, xdrv;
        logic [31:0] xdout;
    } vec_t;

    localparam int NV = 25;
    // fields: ce1 ce2 cpu ctl adv gw bw ben addr din flow ilv oe xdrv xdout
    localparam vec_t VECS [NV] = '{
        '{0,0,1,0,1,0,1,4'hF,6'd8 ,32'h11111111,0,0,0,0,32'h0},        // R4 R8 start write 8
        '{1,0,1,1,0,1,0,4'h0,6'd0 ,32'h22222222,0,0,0,0,32'h0},        // R5 step write 9, ce1 high
        '{0,0,1,1,0,0,1,4'hF,6'd63,32'h33333333,0,0,0,0,32'h0},        // R5 write 10
        '{0,0,1,1,0,0,1,4'hF,6'd63,32'h44444444,0,0,0,0,32'h0},        // R5 write 11
        '{0,0,1,1,0,0,1,4'hF,6'd63,32'h55555555,0,0,0,0,32'h0},        // R6 wrap, write 8
        '{0,0,1,0,1,1,1,4'hF,6'd9 ,32'h0,0,0,0,1,32'h22222222},        // R4 R10 start read 9
        '{0,0,1,1,0,1,1,4'hF,6'd0 ,32'h0,0,0,0,1,32'h33333333},        // R6 10
        '{0,0,1,1,0,1,1,4'hF,6'd0 ,32'h0,0,0,0,1,32'h44444444},        // R6 11
        '{0,0,1,1,0,1,1,4'hF,6'd0 ,32'h0,0,0,0,1,32'h55555555},        // R6 wrap to 8
        '{0,0,1,1,1,1,1,4'hF,6'd0 ,32'h0,0,0,0,1,32'h55555555},        // R5 stay on 8
        '{0,0,1,0,1,1,0,4'b1010,6'd10,32'hAABBCCDD,0,0,0,0,32'h0},     // R8 bytes 0 and 2
        '{0,0,0,1,1,0,0,4'h0,6'd10,32'hFFFFFFFF,0,0,0,1,32'h33BB33DD}, // R2 R11 write inputs ignored
        '{0,0,1,0,1,1,0,4'hF,6'd11,32'h0,0,0,0,0,32'h0},               // R9 write of no bytes
        '{0,0,0,1,1,1,1,4'hF,6'd11,32'h0,0,0,0,1,32'h44444444},        // R9 word 11 intact
        '{1,0,0,1,1,1,1,4'hF,6'd3 ,32'h0,0,0,0,1,32'h44444444},        // R3 cpu strobe masked -> stay
        '{1,0,1,0,1,0,1,4'hF,6'd3 ,32'hDEADBEEF,0,0,0,0,32'h0},        // R3 R11 deselect
        '{0,0,1,0,1,1,1,4'hF,6'd9 ,32'h0,0,1,0,1,32'h22222222},        // R7 interleaved from 9
        '{0,0,1,1,0,1,1,4'hF,6'd0 ,32'h0,0,1,0,1,32'h55555555},        // R7 8
        '{0,0,1,1,0,1,1,4'hF,6'd0 ,32'h0,0,1,0,1,32'h44444444},        // R7 R3 11 not overwritten
        '{0,0,1,1,0,1,1,4'hF,6'd0 ,32'h0,0,1,0,1,32'h33BB33DD},        // R7 10
        '{0,1,1,0,1,0,1,4'hF,6'd8 ,32'hCAFEF00D,0,0,0,0,32'h0},        // R3 ce2 off, ctl strobe
        '{0,1,0,1,1,1,1,4'hF,6'd8 ,32'h0,0,0,0,0,32'h0},               // R3 ce2 off, cpu strobe
        '{0,0,1,0,1,1,1,4'hF,6'd8 ,32'h0,0,0,1,0,32'h0},               // R12 dummy read 8
        '{0,0,1,1,0,1,1,4'hF,6'd0 ,32'h0,0,0,1,0,32'h0},               // R12 dummy read 9
        '{0,0,1,1,0,1,1,4'hF,6'd0 ,32'h0,0,0,0,1,32'h33BB33DD}         // R12 counter moved to 10
    };

    task automatic put(input vec_t v);
        ce1_n = v.ce1_n; ce2_n = v.ce2_n; strb_cpu_n = v.cpu_n; strb_ctl_n = v.ctl_n;
        adv_n = v.adv_n; gwr_n = v.gw_n; bwr_n = v.bw_n; ben_n = v.ben_n;
        addr = v.addr; din = v.din; flow_n = v.flow_n; ilv_sel = v.ilv; oe_n = v.oe_n;
    endtask

    task automatic cmd(input logic c1, input logic c2, input logic cp, input logic ct,
                       input logic av, input logic gw, input logic [5:0] a,
                       input logic [31:0] d);
        ce1_n = c1; ce2_n = c2; strb_cpu_n = cp; strb_ctl_n = ct; adv_n = av;
        gwr_n = gw; bwr_n = 1'b1; ben_n = 4'hF; addr = a; din = d;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic xd, input logic [31:0] xq);
        total++;
        if (drive !== xd || dout !== xq) begin
            bad++;
            $display("FAIL %s: drive=%0b dout=%h, expected drive=%0b dout=%h",
                     tag, drive, dout, xd, xq);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step();
        check("R1 reset", 1'b0, 32'h0);
        rst = 1'b0;
        step();
        check("R1 after reset", 1'b0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            put(VECS[i]);
            step();
            check($sformatf("vector %0d", i), VECS[i].xdrv, VECS[i].xdout);
        end

        // registered mode
        flow_n = 1'b1; ilv_sel = 1'b0; oe_n = 1'b0;
        cmd(1, 0, 1, 0, 1, 1, 6'd0, 32'h0);           // deselect
        step();
        check("R13 pending word still driven", 1'b1, 32'h33BB33DD);
        cmd(0, 0, 1, 0, 1, 1, 6'd8, 32'h0);           // start read 8
        step();
        check("R10 registered, first slot empty", 1'b0, 32'h0);
        cmd(0, 0, 1, 1, 0, 1, 6'd0, 32'h0);
        step();
        check("R10 R3 word 8 one edge later", 1'b1, 32'h55555555);
        cmd(0, 0, 1, 1, 0, 1, 6'd0, 32'h0);
        step();
        check("R10 word 9", 1'b1, 32'h22222222);
        cmd(1, 0, 1, 0, 1, 1, 6'd0, 32'h0);
        step();
        check("R13 word 10 after deselect", 1'b1, 32'h33BB33DD);
        step();
        check("R13 one slot only", 1'b0, 32'h0);
        cmd(0, 0, 1, 0, 1, 0, 6'd12, 32'h12345678);   // global write 12
        step();
        check("R11 registered write", 1'b0, 32'h0);
        cmd(1, 0, 1, 0, 1, 1, 6'd0, 32'h0);
        step();
        check("R11 write slot quiet", 1'b0, 32'h0);
        cmd(0, 0, 1, 0, 1, 1, 6'd12, 32'h0);
        step();
        cmd(1, 0, 1, 0, 1, 1, 6'd0, 32'h0);
        step();
        check("R8 registered read 12", 1'b1, 32'h12345678);

        // asynchronous output enable
        oe_n = 1'b1;
        #1;
        check("R12 oe high without clock", 1'b0, 32'h0);
        oe_n = 1'b0;
        #1;
        check("R12 oe low again", 1'b1, 32'h12345678);

        // reset in the middle of a read
        flow_n = 1'b0;
        cmd(0, 0, 1, 0, 1, 1, 6'd12, 32'h0);
        rst = 1'b1;
        step();
        check("R1 mid-run reset", 1'b0, 32'h0);
        rst = 1'b0;
        cmd(1, 0, 1, 0, 1, 1, 6'd0, 32'h0);
        step();
        check("R1 quiet after reset", 1'b0, 32'h0);

        finish_run();
    end

endmodule